// File: doc/BRIEF.md
# Dual-Pattern Preamble Matcher and Byte Aligner

This block watches a recovered serial receive bit stream, one bit per strobe, for either of two programmable bit patterns. While it hunts, no data reaches its output. When one of the enabled patterns is found in the most recent received bits, the block locks. It records which pattern was found and takes the byte boundary from that point, so the bit right after the pattern becomes the first bit of a new byte. From then on it packs the incoming bits into bytes and presents each byte on a valid/ready output stream.

Each of the two pattern slots has its own contents, its own length (4 to 32 bits) and its own enable. Once locked, the block stops searching until a rearm pulse returns it to hunting. The output stream follows a one-entry rule for back-pressure. A byte that has been presented stays on the output, unchanged, until the consumer raises ready. If another byte completes while the output is still occupied, that new byte is discarded. The held byte is kept and the byte boundary does not move.

Top module: `preamble_sync_aligner`

## Requirements
- R1: While the block is hunting, no new byte is produced: byte_valid_o does not rise unless the block was locked in the cycle before.
- R2: Two pattern slots are searched in parallel, each with its own pattern word, length and enable. Either slot can cause a lock.
- R3: The effective length of each slot is its length field clamped to the range 4 to 32. A field below 4 acts as 4, and a field above 32 acts as 32.
- R4: A slot of effective length N compares the last N received bits against bits N-1..0 of its pattern word. The earliest of those bits is compared with bit N-1 and the most recent with bit 0. A match also requires that at least N bits have been received since reset or since the last rearm.
- R5: After a lock, the first following bit becomes bit 7 of the next byte, so bits arrive most significant bit first. Every 8 strobed bits form one byte.
- R6: matched_o rises in the cycle after the strobe that carried the final pattern bit. match_id_o is 0 for slot 0 and 1 for slot 1.
- R7: If both slots match on the same bit, slot 0 wins and match_id_o is 0.
- R8: Once locked, matched_o and match_id_o hold until rearm_i. Rearm returns the block to hunting and clears the bit history and the received-bit count. A bit strobed in the same cycle as rearm is discarded.
- R9: A disabled slot never matches. With both slots disabled, the block stays in the hunting state whatever bits arrive.
- R10: While byte_valid_o is high and byte_ready_i is low, byte_o stays stable. A byte completed during that time is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Received data bit |
| bit_stb_i | input | 1 | Qualifies bit_i for one cycle |
| pat0_i | input | 32 | Pattern word, slot 0 |
| pat1_i | input | 32 | Pattern word, slot 1 |
| len0_i | input | 6 | Pattern length field, slot 0 |
| len1_i | input | 6 | Pattern length field, slot 1 |
| en0_i | input | 1 | Slot 0 enable |
| en1_i | input | 1 | Slot 1 enable |
| rearm_i | input | 1 | Return to hunting (single-cycle pulse) |
| byte_o | output | 8 | Assembled byte |
| byte_valid_o | output | 1 | byte_o holds a byte not yet taken |
| byte_ready_i | input | 1 | Consumer accepts byte_o |
| matched_o | output | 1 | Locked after a pattern match |
| match_id_o | output | 1 | Slot that caused the lock |

## Verification
The bench builds the block with its default parameters: a 32-bit history, 6-bit length fields and 8-bit bytes. These defaults allow the shortest and longest patterns, and length fields outside the legal range in both directions, to be checked directly. Because the history width is the 32-bit maximum, an all-zero pattern depends entirely on the received-bit count to avoid an early match. That lets the bench see the fill guard and the discarding of a bit strobed during rearm. A vector table sends both slots patterns that do and do not overlap, including the case where both match on the same bit. Directed tests then hold off ready to show a byte being kept and the next one dropped.

// File: rtl/psa_pkg.sv
package psa_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } psa_state_e;

  localparam int SLOTS = 2;
endpackage

// File: rtl/psa_shifter.sv
module psa_shifter #(
  parameter int W     = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic             bit_i,
  output logic [W-1:0]     win_o,
  output logic [LEN_W-1:0] fill_o
);
  localparam logic [LEN_W-1:0] FILL_MAX = LEN_W'(W);

  logic [W-1:0]     hist_q;
  logic [LEN_W-1:0] fill_q;

  // window as it stands once the current bit is included
  assign win_o  = {hist_q[W-2:0], bit_i};
  assign fill_o = (fill_q == FILL_MAX) ? FILL_MAX : fill_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (stb_i) begin
      hist_q <= win_o;
      fill_q <= fill_o;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_MAX); // R4

  AST_CLEAR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> fill_q == '0); // R8
endmodule

// File: rtl/psa_slot_cmp.sv
module psa_slot_cmp #(
  parameter int W       = 32,
  parameter int LEN_W   = 6,
  parameter int MIN_LEN = 4
) (
  input  logic             stb_i,
  input  logic             en_i,
  input  logic [W-1:0]     pat_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [W-1:0]     win_i,
  input  logic [LEN_W-1:0] fill_i,
  output logic             hit_o
);
  localparam logic [LEN_W-1:0] LMIN = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LMAX = LEN_W'(W);

  logic [LEN_W-1:0] eff_len;
  logic [W-1:0]     mask;
  logic [W-1:0]     diff;

  always_comb begin
    if (len_i < LMIN)      eff_len = LMIN;
    else if (len_i > LMAX) eff_len = LMAX;
    else                   eff_len = len_i;
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      mask[i] = (LEN_W'(i) < eff_len);
    end
  end

  assign diff  = (win_i ^ pat_i) & mask;
  assign hit_o = stb_i && en_i && (fill_i >= eff_len) && (diff == '0);
endmodule

// File: rtl/psa_deser.sv
module psa_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  input  logic              ready_i
);
  localparam int               CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] acc_q;
  logic [BYTE_W-1:0] next_acc;
  logic              done;

  assign next_acc = {acc_q[BYTE_W-2:0], bit_i};
  assign done     = stb_i && lock_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (stb_i && lock_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      acc_q <= next_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (done && (!valid_o || ready_i)) begin
      valid_o <= 1'b1;
      data_o  <= next_acc;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_NO_BYTE_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(lock_i)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(data_o)); // R10

  AST_ALIGN_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_i) |-> cnt_q == '0); // R5
endmodule

// File: rtl/preamble_sync_aligner.sv
module preamble_sync_aligner #(
  parameter int W       = 32,
  parameter int LEN_W   = 6,
  parameter int MIN_LEN = 4,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              bit_stb_i,
  input  logic [W-1:0]      pat0_i,
  input  logic [W-1:0]      pat1_i,
  input  logic [LEN_W-1:0]  len0_i,
  input  logic [LEN_W-1:0]  len1_i,
  input  logic              en0_i,
  input  logic              en1_i,
  input  logic              rearm_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic              matched_o,
  output logic              match_id_o
);
  import psa_pkg::*;

  psa_state_e state_q;

  logic             hunt_stb;
  logic             lock_stb;
  logic [W-1:0]     win;
  logic [LEN_W-1:0] fill;
  logic [SLOTS-1:0] hit;
  logic             match_now;

  logic [W-1:0]     pat_a [SLOTS];
  logic [LEN_W-1:0] len_a [SLOTS];
  logic [SLOTS-1:0] en_a;

  assign pat_a[0] = pat0_i;
  assign pat_a[1] = pat1_i;
  assign len_a[0] = len0_i;
  assign len_a[1] = len1_i;
  assign en_a     = {en1_i, en0_i};

  assign hunt_stb  = bit_stb_i && !rearm_i && (state_q == ST_HUNT);
  assign lock_stb  = bit_stb_i && !rearm_i && (state_q == ST_LOCK);
  assign match_now = |hit;

  psa_shifter #(.W(W), .LEN_W(LEN_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (rearm_i),
    .stb_i  (hunt_stb),
    .bit_i  (bit_i),
    .win_o  (win),
    .fill_o (fill)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    psa_slot_cmp #(.W(W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_cmp (
      .stb_i  (hunt_stb),
      .en_i   (en_a[s]),
      .pat_i  (pat_a[s]),
      .len_i  (len_a[s]),
      .win_i  (win),
      .fill_i (fill),
      .hit_o  (hit[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HUNT;
      match_id_o <= 1'b0;
    end else if (rearm_i) begin
      state_q    <= ST_HUNT;
      match_id_o <= 1'b0;
    end else if (state_q == ST_HUNT && match_now) begin
      state_q    <= ST_LOCK;
      match_id_o <= !hit[0];
    end
  end

  assign matched_o = (state_q == ST_LOCK);

  psa_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_i  (state_q == ST_LOCK),
    .clr_i   (rearm_i || match_now),
    .stb_i   (lock_stb),
    .bit_i   (bit_i),
    .data_o  (byte_o),
    .valid_o (byte_valid_o),
    .ready_i (byte_ready_i)
  );

  AST_SLOT0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matched_o) && match_id_o |-> !$past(hit[0])); // R7

  AST_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matched_o) |-> (match_id_o ? $past(en1_i) : $past(en0_i))); // R9

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    matched_o && !rearm_i |=> matched_o && $stable(match_id_o)); // R8

  AST_REARM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> !matched_o); // R8
endmodule

// File: tb/preamble_sync_aligner_bench.sv
module preamble_sync_aligner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_i = 1'b0;
  logic        bit_stb_i = 1'b0;
  logic [31:0] pat0_i = '0;
  logic [31:0] pat1_i = '0;
  logic [5:0]  len0_i = 6'd4;
  logic [5:0]  len1_i = 6'd4;
  logic        en0_i = 1'b0;
  logic        en1_i = 1'b0;
  logic        rearm_i = 1'b0;
  logic [7:0]  byte_o;
  logic        byte_valid_o;
  logic        byte_ready_i = 1'b1;
  logic        matched_o;
  logic        match_id_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  preamble_sync_aligner u_preamble_sync_aligner (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_i        (bit_i),
    .bit_stb_i    (bit_stb_i),
    .pat0_i       (pat0_i),
    .pat1_i       (pat1_i),
    .len0_i       (len0_i),
    .len1_i       (len1_i),
    .en0_i        (en0_i),
    .en1_i        (en1_i),
    .rearm_i      (rearm_i),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .byte_ready_i (byte_ready_i),
    .matched_o    (matched_o),
    .match_id_o   (match_id_o)
  );

  typedef struct packed {
    logic [31:0] p0;
    logic [31:0] p1;
    logic [5:0]  l0;
    logic [5:0]  l1;
    logic        e0;
    logic        e1;
    logic [31:0] sp;
    logic [5:0]  sl;
    logic [7:0]  dat;
    logic        id;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_000B, 32'h0,         6'd4,  6'd4,  1'b1, 1'b0, 32'h0000_000B, 6'd4,  8'hA5, 1'b0},
    '{32'h0,         32'hD391_E5C7, 6'd4,  6'd32, 1'b0, 1'b1, 32'hD391_E5C7, 6'd32, 8'h3C, 1'b1},
    '{32'h0000_02DD, 32'h0000_0F0F, 6'd10, 6'd16, 1'b1, 1'b1, 32'h0000_02DD, 6'd10, 8'hFF, 1'b0},
    '{32'h0000_02DD, 32'h0000_0F0F, 6'd10, 6'd16, 1'b1, 1'b1, 32'h0000_0F0F, 6'd16, 8'h81, 1'b1},
    '{32'h0000_005A, 32'h0000_000A, 6'd8,  6'd4,  1'b1, 1'b1, 32'h0000_005A, 6'd8,  8'h00, 1'b0},
    '{32'h0000_005A, 32'h0000_000A, 6'd8,  6'd4,  1'b0, 1'b1, 32'h0000_005A, 6'd8,  8'h7E, 1'b1},
    '{32'h8000_0001, 32'h0,         6'd40, 6'd4,  1'b1, 1'b0, 32'h8000_0001, 6'd32, 8'hC3, 1'b0},
    '{32'hFFFF_FFF9, 32'h0,         6'd0,  6'd4,  1'b1, 1'b0, 32'h0000_0009, 6'd4,  8'h5A, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_i     = b;
    bit_stb_i = 1'b1;
    @(negedge clk);
    bit_stb_i = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) send_bit(v[k]);
  endtask

  task automatic rearm();
    @(negedge clk);
    rearm_i = 1'b1;
    @(negedge clk);
    rearm_i = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset byte_valid", 32'(byte_valid_o), 0);
    chk("R6 reset matched", 32'(matched_o), 0);
    rst_n = 1'b1;

    // Table of vectors: noise, pattern, one data byte
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      pat0_i = VEC[v].p0; pat1_i = VEC[v].p1;
      len0_i = VEC[v].l0; len1_i = VEC[v].l1;
      en0_i  = VEC[v].e0; en1_i  = VEC[v].e1;
      rearm();
      send_bits(32'h0, 16);
      chk($sformatf("R1 v%0d no byte while hunting", v), 32'(byte_valid_o), 0);
      send_bits(VEC[v].sp >> 1, int'(VEC[v].sl) - 1);
      chk($sformatf("R4 v%0d no early match", v), 32'(matched_o), 0);
      send_bit(VEC[v].sp[0]);
      chk($sformatf("R6 v%0d matched", v), 32'(matched_o), 1);
      chk($sformatf("R2 R7 v%0d match id", v), 32'(match_id_o), 32'(VEC[v].id));
      send_bits(32'(VEC[v].dat), 8);
      chk($sformatf("R5 v%0d byte valid", v), 32'(byte_valid_o), 1);
      chk($sformatf("R5 R3 v%0d byte value", v), 32'(byte_o), 32'(VEC[v].dat));
    end

    // R4: all-zero pattern needs a full count of received bits
    @(negedge clk);
    pat0_i = 32'h0; len0_i = 6'd8; en0_i = 1'b1; en1_i = 1'b0;
    rearm();
    send_bits(32'h0, 7);
    chk("R4 fill guard before 8 bits", 32'(matched_o), 0);
    send_bit(1'b0);
    chk("R4 fill guard at 8 bits", 32'(matched_o), 1);

    // R8: rearm wins over a strobe in the same cycle, history cleared
    @(negedge clk);
    rearm_i = 1'b1; bit_i = 1'b0; bit_stb_i = 1'b1;
    @(negedge clk);
    rearm_i = 1'b0; bit_stb_i = 1'b0;
    chk("R8 rearm returns to hunt", 32'(matched_o), 0);
    send_bits(32'h0, 7);
    chk("R8 strobe during rearm discarded", 32'(matched_o), 0);
    send_bit(1'b0);
    chk("R8 relock after rearm", 32'(matched_o), 1);

    // R9: both slots disabled
    @(negedge clk);
    en0_i = 1'b0; en1_i = 1'b0; len0_i = 6'd4;
    rearm();
    send_bits(32'h0, 32);
    send_bits(32'hFFFF_FFFF, 8);
    chk("R9 both disabled stays hunting", 32'(matched_o), 0);
    chk("R9 both disabled no byte", 32'(byte_valid_o), 0);

    // R10: back-pressure holds first byte, drops second
    @(negedge clk);
    pat0_i = 32'hB; len0_i = 6'd4; en0_i = 1'b1;
    pat1_i = 32'h33; len1_i = 6'd8; en1_i = 1'b1;
    byte_ready_i = 1'b0;
    rearm();
    send_bits(32'h0, 16);
    send_bits(32'hB, 4);
    send_bits(32'hC5, 8);
    chk("R10 first byte valid", 32'(byte_valid_o), 1);
    chk("R10 first byte value", 32'(byte_o), 32'hC5);
    send_bits(32'h33, 8);
    chk("R10 held while not ready", 32'(byte_o), 32'hC5);
    chk("R8 slot1 pattern after lock ignored", 32'(match_id_o), 0);
    @(negedge clk);
    byte_ready_i = 1'b1;
    @(negedge clk);
    chk("R10 released after ready", 32'(byte_valid_o), 0);
    send_bits(32'h6E, 8);
    chk("R5 alignment kept after drop", 32'(byte_o), 32'h6E);
    chk("R8 still locked", 32'(matched_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule